// File: doc/BRIEF.md
# Video Status Port with Vertical Retrace Event

This block sits next to a raster timing generator and turns that generator's blanking and retrace levels into a status byte that a processor can read. The byte has one bit that says when video memory can be written without visible corruption, and one bit that marks the vertical retrace interval. Polling software reads this byte to line its updates up with the display.

The timing inputs are asynchronous to the register clock. They pass through a two-flop synchroniser and are then held in a status register. The block also detects the rising edge of the synchronised retrace level. Each edge produces a single-cycle start pulse and sets a sticky pending flag. A read of the status address clears the flag, so the pulse or the flag can drive a simple interrupt line. Reads use a plain synchronous interface: a read strobe and an address in one cycle give the data in the next.

Top module: `video_status_port`

## Requirements
- R1: A read with `rd_en` high and `rd_addr` equal to 0x3DA returns the status byte on `rd_data` after the next clock edge. In any cycle after an edge with no matching read, `rd_data` is 0x00.
- R2: Status bit 0 (the memory-safe bit) is 1 exactly when the synchronised horizontal blank or vertical blank input is 1.
- R3: Status bit 3 is 1 throughout the synchronised vertical retrace interval and 0 at all other times.
- R4: Status bits 1, 2, 4, 5, 6 and 7 always read 0.
- R5: For each 0-to-1 change of status bit 3, `retrace_start` is high for exactly one clock. That clock is the first one in which the status register holds bit 3 as 1. The pulse is never high for two clocks in a row.
- R6: `retrace_pending` goes high in the same clock as `retrace_start`. It stays high until an edge at which a read of 0x3DA is sampled, and it falls after that edge.
- R7: If a retrace start and a status read coincide at the same edge, the pending flag ends up set.
- R8: A read at any address other than 0x3DA returns 0x00 and leaves `retrace_pending` unchanged.
- R9: Synchronous active-high reset clears `rd_data`, `retrace_start`, `retrace_pending`, the status bits and the synchroniser stages.
- R10: A timing input level that is stable before clock edge k appears in a read issued at edge k+3 and in no earlier read. This is two synchroniser flops plus the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| hblank_i | input | 1 | Horizontal blanking level, asynchronous |
| vblank_i | input | 1 | Vertical blanking level, asynchronous |
| vretrace_i | input | 1 | Vertical retrace level, asynchronous |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (16) | Read I/O address |
| rd_data | output | 8 | Registered read data |
| retrace_start | output | 1 | One-clock pulse at the start of vertical retrace |
| retrace_pending | output | 1 | Sticky retrace-start flag, cleared by a status read |

## Verification
The bound assertions check on every cycle that:
- reserved bits stay zero;
- `rd_data` is idle after any cycle without a matching read;
- the start pulse never lasts two clocks and always coincides with the pending flag;
- the flag only falls after a status read and otherwise holds;
- reset clears every output.

The exact latency through the synchroniser and the mapping of the blanking and retrace levels onto bits 0 and 3 can only be shown by the bench. Its reference model is compared on every clock. So can the set-wins collision between a retrace start and a clearing read, and the fact that a read at a neighbouring address does not disturb the flag. The bench drives directed sequences for all of these.

// File: rtl/vstat_pkg.sv
package vstat_pkg;

  localparam int STAT_W      = 8;
  localparam int SAFE_BIT    = 0;
  localparam int RETRACE_BIT = 3;
  localparam logic [STAT_W-1:0] LIVE_MASK =
    (STAT_W'(1) << SAFE_BIT) | (STAT_W'(1) << RETRACE_BIT);
  localparam logic [STAT_W-1:0] RSVD_MASK = ~LIVE_MASK;

  // One sample of the raster timing levels.
  typedef struct packed {
    logic hblank;
    logic vblank;
    logic vretrace;
  } vtiming_t;

  localparam int TIMING_W = $bits(vtiming_t);

endpackage

// File: rtl/vstat_sync.sv
module vstat_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= '0;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/vstat_retrace_evt.sv
module vstat_retrace_evt (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic clear_i,
  output logic level_q_o,
  output logic pulse_o,
  output logic pending_o
);

  logic level_q;
  logic pulse_q;
  logic pending_q;
  logic rise;

  // The held level doubles as the edge-detect history, so the pulse lines up
  // with the first cycle the status bit shows retrace.
  assign rise = level_i & ~level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q   <= 1'b0;
      pulse_q   <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      level_q   <= level_i;
      pulse_q   <= rise;
      pending_q <= rise | (pending_q & ~clear_i);  // set beats clear
    end
  end

  assign level_q_o = level_q;
  assign pulse_o   = pulse_q;
  assign pending_o = pending_q;

endmodule

// File: rtl/vstat_rdport.sv
module vstat_rdport #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h03DA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] status_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] data_q;

  assign hit_o = rd_en && (rd_addr == STAT_ADDR);

  always_ff @(posedge clk) begin
    if (rst)        data_q <= '0;
    else if (hit_o) data_q <= status_i;
    else            data_q <= '0;
  end

  assign rd_data_o = data_q;

endmodule

// File: rtl/video_status_port.sv
module video_status_port #(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h03DA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hblank_i,
  input  logic              vblank_i,
  input  logic              vretrace_i,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              retrace_start,
  output logic              retrace_pending
);

  import vstat_pkg::*;

  vtiming_t              raw;
  vtiming_t              synced;
  logic [TIMING_W-1:0]   synced_bits;
  logic                  safe_q;
  logic                  retrace_q;
  logic                  rd_hit;
  logic [STAT_W-1:0]     status_byte;

  assign raw.hblank   = hblank_i;
  assign raw.vblank   = vblank_i;
  assign raw.vretrace = vretrace_i;

  vstat_sync #(
    .WIDTH  (TIMING_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (synced_bits)
  );

  assign synced = vtiming_t'(synced_bits);

  always_ff @(posedge clk) begin
    if (rst) safe_q <= 1'b0;
    else     safe_q <= synced.hblank | synced.vblank;
  end

  vstat_retrace_evt u_evt (
    .clk       (clk),
    .rst       (rst),
    .level_i   (synced.vretrace),
    .clear_i   (rd_hit),
    .level_q_o (retrace_q),
    .pulse_o   (retrace_start),
    .pending_o (retrace_pending)
  );

  always_comb begin
    status_byte              = '0;
    status_byte[SAFE_BIT]    = safe_q;
    status_byte[RETRACE_BIT] = retrace_q;
  end

  vstat_rdport #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (STAT_W),
    .STAT_ADDR (STAT_ADDR)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .status_i  (status_byte),
    .hit_o     (rd_hit),
    .rd_data_o (rd_data)
  );

endmodule

// File: rtl/vstat_chk.sv
module vstat_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h03DA
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              retrace_start,
  input logic              retrace_pending
);

  import vstat_pkg::*;

  logic hit;
  assign hit = rd_en && (rd_addr == STAT_ADDR);

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RSVD_MASK) == 8'h00);

  // R1
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(hit) |-> rd_data == 8'h00);

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    retrace_start |=> !retrace_start);

  // R6
  pulse_sets_chk: assert property (@(posedge clk) disable iff (rst)
    retrace_start |-> retrace_pending);

  // R8
  pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(retrace_pending) && !$past(hit)) |-> retrace_pending);

  // R6
  pending_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(retrace_pending) |-> $past(hit));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == 8'h00 && !retrace_start && !retrace_pending));

endmodule

bind video_status_port vstat_chk #(
  .ADDR_W    (ADDR_W),
  .STAT_ADDR (STAT_ADDR)
) u_vstat_chk (
  .clk             (clk),
  .rst             (rst),
  .rd_en           (rd_en),
  .rd_addr         (rd_addr),
  .rd_data         (rd_data),
  .retrace_start   (retrace_start),
  .retrace_pending (retrace_pending)
);

// File: tb/test_video_status_port.sv
`timescale 1ns/1ps
module test_video_status_port;

  localparam int ADDR_W = 16;
  localparam logic [15:0] STAT = 16'h03DA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hb = 1'b0, vb = 1'b0, vr = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        retrace_start, retrace_pending;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit model_live = 0;

  always #4 clk = ~clk;  // 125 MHz

  video_status_port i_video_status_port (
    .clk             (clk),
    .rst             (rst),
    .hblank_i        (hb),
    .vblank_i        (vb),
    .vretrace_i      (vr),
    .rd_en           (rd_en),
    .rd_addr         (rd_addr),
    .rd_data         (rd_data),
    .retrace_start   (retrace_start),
    .retrace_pending (retrace_pending)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference model: history of sampled inputs, expected outputs per edge.
  logic [2:0] hist[$];
  logic [7:0] m_stat = 0, m_rd = 0;
  logic       m_pulse = 0, m_pend = 0;

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      m_stat = 0; m_rd = 0; m_pulse = 0; m_pend = 0;
    end else begin
      logic [7:0] old_stat;
      logic [2:0] cur;
      logic       hit;
      old_stat = m_stat;
      hist.push_back({hb, vb, vr});
      cur = (hist.size() >= 3) ? hist[hist.size()-3] : 3'b000;
      m_stat = 8'h00;
      m_stat[0] = cur[2] | cur[1];
      m_stat[3] = cur[0];
      m_pulse = m_stat[3] & ~old_stat[3];
      hit = rd_en && (rd_addr == STAT);
      m_rd = hit ? old_stat : 8'h00;
      m_pend = m_pulse | (m_pend & ~hit);
      if (hist.size() > 6) void'(hist.pop_front());
    end
    model_live = 1;
  end

  always @(negedge clk) begin
    if (model_live && !done) begin
      check("R1 rd_data", rd_data, m_rd);
      check("R2 safe bit", {7'd0, rd_data[0]}, {7'd0, m_rd[0]});
      check("R3 retrace bit", {7'd0, rd_data[3]}, {7'd0, m_rd[3]});
      check("R4 reserved bits", rd_data & 8'hF6, 8'h00);
      check("R5 retrace_start", {7'd0, retrace_start}, {7'd0, m_pulse});
      check("R6 retrace_pending", {7'd0, retrace_pending}, {7'd0, m_pend});
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_stat();
    rd_en = 1'b1; rd_addr = STAT;
    step();
    rd_en = 1'b0;
  endtask

  initial begin
    step(3);
    // R9: reset state
    check("R9 rd_data after reset", rd_data, 8'h00);
    check("R9 pulse after reset", {7'd0, retrace_start}, 8'h00);
    check("R9 pending after reset", {7'd0, retrace_pending}, 8'h00);
    rst = 1'b0;
    step(2);

    // R10: latency, read every cycle after raising hblank
    hb = 1'b1; rd_en = 1'b1; rd_addr = STAT;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R10 latency", {7'd0, rd_data[0]}, (i < 3) ? 8'h00 : 8'h01);
    end
    rd_en = 1'b0;
    hb = 1'b0; step(4);

    // R2: vblank alone sets the safe bit
    vb = 1'b1; step(4);
    read_stat();
    check("R2 vblank safe", rd_data, 8'h01);
    vb = 1'b0; step(4);
    read_stat();
    check("R2 active display", rd_data, 8'h00);

    // R3 R5 R6: retrace window
    vb = 1'b1; step(2);
    vr = 1'b1; step(5);
    read_stat();
    check("R3 retrace read", rd_data, 8'h09);
    check("R6 cleared by read", {7'd0, retrace_pending}, 8'h00);
    step(3);
    vr = 1'b0; step(3);
    vb = 1'b0; step(4);

    // R8: other addresses leave the flag alone
    vr = 1'b1; step(4);
    check("R6 pending set", {7'd0, retrace_pending}, 8'h01);
    rd_en = 1'b1; rd_addr = STAT + 16'd1;
    step(3);
    rd_en = 1'b0;
    check("R8 pending kept", {7'd0, retrace_pending}, 8'h01);
    check("R8 data zero", rd_data, 8'h00);
    read_stat();
    check("R6 clear", {7'd0, retrace_pending}, 8'h00);
    vr = 1'b0; step(5);

    // R7: clear read and retrace start at the same edge
    vr = 1'b1;
    step(2);
    rd_en = 1'b1; rd_addr = STAT;
    step();
    rd_en = 1'b0;
    check("R7 pulse at collision", {7'd0, retrace_start}, 8'h01);
    check("R7 set wins", {7'd0, retrace_pending}, 8'h01);
    step(2);
    vr = 1'b0; step(4);

    // Mixed pattern with back-to-back retrace bursts
    for (int k = 0; k < 40; k++) begin
      hb = k[0]; vb = (k % 7) < 2; vr = (k % 9) < 3;
      rd_en = (k % 3) == 0; rd_addr = (k % 5 == 0) ? STAT + 16'd8 : STAT;
      step();
    end
    rd_en = 1'b0; hb = 0; vb = 0; vr = 0;

    // R9: reset with a pending flag
    vr = 1'b1; step(4);
    rst = 1'b1; step(2);
    check("R9 pending reset", {7'd0, retrace_pending}, 8'h00);
    rst = 1'b0; vr = 1'b0; step(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule